// File: doc/BRIEF.md
# Network Controller Interrupt Status Aggregator

This block keeps the interrupt status word of a packet DMA controller. The transmit engine, the receive engine, the general-purpose timer and the bus interface send it single-cycle event pulses. Each pulse sets a sticky status bit, and the bit stays set until the host clears it. A separate enable mask decides which bits may raise an interrupt. From the enabled bits the block forms two summary flags. One covers routine completion events and the other covers error and stall conditions. The interrupt line follows these flags one clock later.

The host reaches the block through a small register port with a one-bit select. Select 0 is the status word and select 1 is the mask. Reads are combinational. A write to the status word clears the bits written as 1. The status word also carries live transmit and receive process-state codes and a latched bus error type code. The transmit-early flag is special: it is set and cleared by FIFO progress signals and never by the host.

Top module: `nic_irq_status`

## Requirements
- R1: After reset all sticky status bits, the bus error code, the mask and `irq_o` are 0. Reading either register then returns 0, apart from the live state fields.
- R2: A 1 on a bit of `evt_i` at W1C positions 0–8, 11 and 13 sets that status bit in the following cycle. The bit then holds after the pulse has ended.
- R3: A status write (`reg_wr_i`=1, `reg_sel_i`=0) clears each W1C bit whose `reg_wdata_i` bit is 1 and leaves bits written 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A mask write (`reg_sel_i`=1) stores `reg_wdata_i[13:0]`, where 1 enables the bit. The mask reads back in bits 13:0, and a bit with mask 0 never contributes to a summary flag or to `irq_o`.
- R5: Status bit 16 is the OR of (status AND mask) over bits 0, 2 and 6.
- R6: Status bit 15 is the OR of (status AND mask) over bits 1, 3, 4, 5, 7, 8, 10, 11 and 13.
- R7: `irq_o` equals (bit 16 OR bit 15) as it stood one clock earlier.
- R8: Bit 10 sets one cycle after `tx_pkt_loaded_i` is 1 while `tx_early_en_i` is 1. It clears one cycle after `tx_pkt_drained_i` is 1, and loading wins when both are 1 in the same cycle. Host writes and `evt_i[10]` have no effect on it.
- R9: Bits 22:20 show `tx_state_i` and bits 19:17 show `rx_state_i` in the same cycle. Neither field affects the summary flags or `irq_o`.
- R10: When `evt_i[13]` is 1, `berr_code_i` is captured. Bits 25:23 show the captured code while bit 13 is set and read 0 while bit 13 is clear.
- R11: Bits 9, 12, 14 and 31:26 of the status word always read 0, and `evt_i[9]` and `evt_i[12]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event pulses, one per status bit position |
| tx_early_en_i | input | 1 | Enables setting of the transmit-early flag |
| tx_pkt_loaded_i | input | 1 | A whole packet has entered the transmit FIFO |
| tx_pkt_drained_i | input | 1 | The packet has fully left the transmit FIFO |
| tx_state_i | input | 3 | Transmit process state code |
| rx_state_i | input | 3 | Receive process state code |
| berr_code_i | input | 3 | Bus error type, valid with evt_i[13] |
| reg_wr_i | input | 1 | Host write strobe |
| reg_sel_i | input | 1 | 0 = status word, 1 = mask |
| reg_wdata_i | input | 14 | Host write data |
| reg_rdata_o | output | 32 | Host read data for the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a host write-1-to-clear landing in the same cycle as a fresh event pulse on the same bit. A second case is a packet-load and a packet-drain indication arriving together on the transmit-early flag. The bench forces both coincidences on purpose, including with mixed bit patterns where only some written bits also see an event. A behavioural model decides the winner from the requirements, and the whole status word and `irq_o` are compared against it on every clock.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int EVT_W   = 14;
  localparam int ST_W    = 3;
  localparam int DW      = 32;
  localparam int TXE_BIT = 10;
  localparam int BER_BIT = 13;
  localparam int AIR_BIT = 15;
  localparam int NIR_BIT = 16;
  localparam int RXS_LSB = 17;
  localparam int TXS_LSB = 20;
  localparam int BEC_LSB = 23;
  // status groups
  localparam logic [EVT_W-1:0] NORM_SET = 14'h0045;
  localparam logic [EVT_W-1:0] ABN_SET  = 14'h2DBA;
  localparam logic [EVT_W-1:0] W1C_SET  = 14'h29FF;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/nic_irq_sticky.sv
module nic_irq_sticky #(
  parameter int W = 14,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  // set dominates clear
  assign q_d = (set_i | (q_q & ~clr_i)) & KEEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/nic_irq_txearly.sv
module nic_irq_txearly (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic loaded_i,
  input  logic drained_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= 1'b0;
    else if (loaded_i && en_i)  q_q <= 1'b1;
    else if (drained_i)         q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/nic_irq_summary.sv
module nic_irq_summary #(
  parameter int W = 14,
  parameter logic [W-1:0] NORM = '0,
  parameter logic [W-1:0] ABN  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] mask_i,
  output logic         nir_o,
  output logic         air_o,
  output logic         irq_o
);
  logic [W-1:0] live;
  logic         irq_q;

  assign live  = sts_i & mask_i;
  assign nir_o = |(live & NORM);
  assign air_o = |(live & ABN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= nir_o | air_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/nic_irq_hostport.sv
module nic_irq_hostport #(
  parameter int W  = 14,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [DW-1:0] status_word_i,
  output logic [W-1:0]  clr_o,
  output logic [W-1:0]  mask_o,
  output logic [DW-1:0] rdata_o
);
  import nic_irq_pkg::*;

  localparam int PAD = DW - W;

  logic [W-1:0] mask_q;
  reg_sel_e     sel;

  assign sel   = reg_sel_e'(sel_i);
  assign clr_o = (wr_i && sel == SEL_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mask_q <= '0;
    else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i;
  end

  assign mask_o  = mask_q;
  assign rdata_o = (sel == SEL_MASK) ? {{PAD{1'b0}}, mask_q} : status_word_i;
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int SW = ST_W,
  parameter int RW = DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [EW-1:0] evt_i,
  input  logic          tx_early_en_i,
  input  logic          tx_pkt_loaded_i,
  input  logic          tx_pkt_drained_i,
  input  logic [SW-1:0] tx_state_i,
  input  logic [SW-1:0] rx_state_i,
  input  logic [SW-1:0] berr_code_i,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [EW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [EW-1:0] clr_vec;
  logic [EW-1:0] sticky_q;
  logic [EW-1:0] sts_q;
  logic [EW-1:0] mask_q;
  logic          txe_q;
  logic          nir;
  logic          air;
  logic [SW-1:0] bec_q;
  logic [RW-1:0] word;

  nic_irq_sticky #(.W(EW), .KEEP(W1C_SET)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i & W1C_SET),
    .clr_i  (clr_vec),
    .q_o    (sticky_q)
  );

  nic_irq_txearly u_txe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_early_en_i),
    .loaded_i  (tx_pkt_loaded_i),
    .drained_i (tx_pkt_drained_i),
    .q_o       (txe_q)
  );

  always_comb begin
    sts_q          = sticky_q;
    sts_q[TXE_BIT] = txe_q;
  end

  // error type capture, shown only while flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             bec_q <= '0;
    else if (evt_i[BER_BIT]) bec_q <= berr_code_i;
  end

  nic_irq_summary #(.W(EW), .NORM(NORM_SET), .ABN(ABN_SET)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_i  (sts_q),
    .mask_i (mask_q),
    .nir_o  (nir),
    .air_o  (air),
    .irq_o  (irq_o)
  );

  always_comb begin
    word                          = '0;
    word[EW-1:0]                  = sts_q;
    word[AIR_BIT]                 = air;
    word[NIR_BIT]                 = nir;
    word[RXS_LSB +: SW]           = rx_state_i;
    word[TXS_LSB +: SW]           = tx_state_i;
    word[BEC_LSB +: SW]           = sts_q[BER_BIT] ? bec_q : '0;
  end

  nic_irq_hostport #(.W(EW), .DW(RW)) u_host (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (reg_wr_i),
    .sel_i         (reg_sel_i),
    .wdata_i       (reg_wdata_i),
    .status_word_i (word),
    .clr_o         (clr_vec),
    .mask_o        (mask_q),
    .rdata_o       (reg_rdata_o)
  );
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk
  import nic_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EVT_W-1:0] evt_i,
  input logic             tx_early_en_i,
  input logic             tx_pkt_loaded_i,
  input logic             tx_pkt_drained_i,
  input logic             reg_wr_i,
  input logic             reg_sel_i,
  input logic [EVT_W-1:0] reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             irq_o,
  input logic [EVT_W-1:0] sts_q,
  input logic [EVT_W-1:0] mask_q
);
  logic [EVT_W-1:0] host_clr;
  assign host_clr = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0;

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & W1C_SET) != '0 |=> (($past(evt_i) & W1C_SET & ~sts_q) == '0));

  p_hold_until_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_q) & W1C_SET & ~$past(host_clr)) & ~sts_q) == '0));

  p_mask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |=> !irq_o);

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(sts_q & mask_q & (NORM_SET | ABN_SET)))));

  p_txe_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pkt_loaded_i && tx_early_en_i) |=> sts_q[TXE_BIT]);

  p_txe_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pkt_drained_i && !(tx_pkt_loaded_i && tx_early_en_i)) |=> !sts_q[TXE_BIT]);

  p_reserved_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o[31:26] == '0 && !reg_rdata_o[14]
                    && !reg_rdata_o[12] && !reg_rdata_o[9]));
endmodule

bind nic_irq_status nic_irq_status_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .evt_i            (evt_i),
  .tx_early_en_i    (tx_early_en_i),
  .tx_pkt_loaded_i  (tx_pkt_loaded_i),
  .tx_pkt_drained_i (tx_pkt_drained_i),
  .reg_wr_i         (reg_wr_i),
  .reg_sel_i        (reg_sel_i),
  .reg_wdata_i      (reg_wdata_i),
  .reg_rdata_o      (reg_rdata_o),
  .irq_o            (irq_o),
  .sts_q            (sts_q),
  .mask_q           (mask_q)
);

// File: tb/nic_irq_status_tb_top.sv
`timescale 1ns/1ps
module nic_irq_status_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] evt_i = '0;
  logic        tx_early_en_i = 1'b0;
  logic        tx_pkt_loaded_i = 1'b0;
  logic        tx_pkt_drained_i = 1'b0;
  logic [2:0]  tx_state_i = '0;
  logic [2:0]  rx_state_i = '0;
  logic [2:0]  berr_code_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [13:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  logic [13:0] m_sts  = '0;
  logic [13:0] m_mask = '0;
  logic [2:0]  m_bec  = '0;
  logic        m_irq  = 1'b0;

  always #4 clk_i = ~clk_i;

  nic_irq_status dut_i (
    .clk_i, .rst_ni, .evt_i, .tx_early_en_i, .tx_pkt_loaded_i, .tx_pkt_drained_i,
    .tx_state_i, .rx_state_i, .berr_code_i, .reg_wr_i, .reg_sel_i, .reg_wdata_i,
    .reg_rdata_o, .irq_o
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    logic [13:0] live = m_sts & m_mask;
    if (reg_sel_i) return {18'b0, m_mask};
    w[13:0]  = m_sts;
    w[16]    = live[0] | live[2] | live[6];
    w[15]    = live[1] | live[3] | live[4] | live[5] | live[7] | live[8]
             | live[10] | live[11] | live[13];
    w[19:17] = rx_state_i;
    w[22:20] = tx_state_i;
    w[25:23] = m_sts[13] ? m_bec : 3'b0;
    return w;
  endfunction

  task automatic compare(input string tag);
    logic [31:0] e = exp_word();
    vectors++;
    if (reg_rdata_o !== e || irq_o !== m_irq) begin
      errors++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               tag, reg_rdata_o, irq_o, e, m_irq);
    end
  endtask

  // drive one cycle, check, advance model across the edge
  task automatic cyc(input logic [13:0] evt, input logic en, input logic ld,
                     input logic dr, input logic wr, input logic sel,
                     input logic [13:0] wd, input string tag);
    logic [31:0] e;
    logic [13:0] nxt;
    logic [13:0] clr;
    evt_i = evt; tx_early_en_i = en; tx_pkt_loaded_i = ld; tx_pkt_drained_i = dr;
    reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    #1;
    compare(tag);
    reg_sel_i = 1'b0;
    #0.1;
    e = exp_word();
    reg_sel_i = sel;
    clr = (wr && !sel) ? wd : 14'h0;
    nxt = m_sts;
    for (int i = 0; i < 14; i++) begin
      if (i == 9 || i == 10 || i == 12) continue;
      nxt[i] = evt[i] | (m_sts[i] & ~clr[i]);
    end
    if (ld && en)  nxt[10] = 1'b1;
    else if (dr)   nxt[10] = 1'b0;
    @(posedge clk_i);
    m_irq = e[16] | e[15];
    if (evt[13]) m_bec = berr_code_i;
    if (wr && sel) m_mask = wd;
    m_sts = nxt;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values, both registers
    cyc('0, 0, 0, 0, 0, 0, '0, "R1 status");
    cyc('0, 0, 0, 0, 0, 1, '0, "R1 mask");
    // R2 pulses set and hold
    cyc(14'h0001, 0, 0, 0, 0, 0, '0, "R2");
    idle(2, "R2 hold");
    cyc(14'h0950, 0, 0, 0, 0, 0, '0, "R2");
    idle(2, "R2 hold");
    // R11 reserved events ignored
    cyc(14'h1200, 0, 0, 0, 0, 0, '0, "R11");
    idle(2, "R11");
    // R4 R5 R7 enable normal group only
    cyc('0, 0, 0, 0, 1, 1, 14'h0045, "R4");
    idle(3, "R5 R7");
    cyc('0, 0, 0, 0, 0, 1, '0, "R4 readback");
    // R3 write zero no effect, then clear
    cyc('0, 0, 0, 0, 1, 0, 14'h0000, "R3 zero");
    idle(1, "R3");
    cyc('0, 0, 0, 0, 1, 0, 14'h0001, "R3 clear");
    idle(2, "R3 R7");
    // R3 set wins over clear, mixed pattern
    cyc(14'h0041, 0, 0, 0, 1, 0, 14'h0851, "R3 collide");
    idle(2, "R3 collide");
    cyc('0, 0, 0, 0, 1, 0, 14'h3FFF, "R3 clear all");
    idle(3, "R3 R7");
    // R6 abnormal group with bus error code, R10
    cyc('0, 0, 0, 0, 1, 1, 14'h2DBA, "R6");
    berr_code_i = 3'd5;
    cyc(14'h2000, 0, 0, 0, 0, 0, '0, "R10");
    berr_code_i = 3'd2;
    idle(2, "R10 R6 R7");
    cyc(14'h2000, 0, 0, 0, 1, 0, 14'h2000, "R10 R3 collide");
    idle(1, "R10");
    cyc('0, 0, 0, 0, 1, 0, 14'h2000, "R10 clear");
    idle(2, "R10 R6");
    cyc(14'h0800, 0, 0, 0, 0, 0, '0, "R6 timer");
    idle(2, "R6");
    cyc(14'h0800, 0, 0, 0, 1, 0, 14'h0800, "R3 collide");
    cyc('0, 0, 0, 0, 1, 0, 14'h0800, "R3");
    idle(2, "R7");
    // R8 transmit early
    cyc('0, 0, 1, 0, 0, 0, '0, "R8 disabled");
    idle(1, "R8");
    cyc('0, 1, 1, 0, 0, 0, '0, "R8 set");
    idle(2, "R8 R6");
    cyc(14'h0400, 1, 0, 0, 1, 0, 14'h0400, "R8 write ignored");
    idle(1, "R8");
    cyc('0, 1, 1, 1, 0, 0, '0, "R8 both");
    idle(1, "R8");
    cyc('0, 1, 0, 1, 0, 0, '0, "R8 drain");
    idle(2, "R8");
    cyc('0, 0, 1, 1, 0, 0, '0, "R8 drain en off");
    cyc(14'h0400, 0, 0, 0, 0, 0, '0, "R8 evt ignored");
    idle(2, "R8");
    // R9 state fields, all enabled but no status
    cyc('0, 0, 0, 0, 1, 1, 14'h3FFF, "R9");
    for (int s = 0; s < 8; s++) begin
      tx_state_i = 3'(s); rx_state_i = 3'(7 - s);
      idle(1, "R9");
    end
    // R2 R5 R6 full sweep of single bits
    for (int b = 0; b < 14; b++) begin
      cyc(14'(1 << b), 0, 0, 0, 0, 0, '0, "R2 sweep");
      idle(2, "R5 R6 R7");
      cyc('0, 0, 0, 0, 1, 0, 14'h3FFF, "R3 sweep");
      idle(1, "R7");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule